// File: doc/BRIEF.md
# Four-Bit Microprogrammed ALU Slice

This block is a 4-bit slice of a microprogrammed datapath. It holds sixteen 4-bit general registers, read through two independent addresses (A and B), and one separate 4-bit working register called Q. In every cycle three 3-bit control fields steer it:

- A source field picks the pair of operands R and S from register A, register B, Q, the external data input and zero.
- A function field picks one of eight arithmetic or logic operations, which produces the result F.
- A destination field decides where F goes, whether the write is shifted, and what appears on the Y output.

Flags (carry-out, overflow, sign, zero) are produced combinationally from the current operation. All register writes happen on the rising clock edge.

Wider words are built by placing several slices side by side. For that, the end bits of the register-file shifter and the Q shifter are brought out as separate shift-in inputs and shift-out outputs. A neighbouring slice can then chain them in either direction.

Top module: `alu_slice`

## Requirements
- R1: While reset is asserted, and for two clock edges after `rst_n` rises, all sixteen general registers and Q are held at 0000.
- R2: The source code on `src_sel` gives the (R, S) pair as follows:
  - 0 gives (A, Q).
  - 1 gives (A, B).
  - 2 gives (0, Q).
  - 3 gives (0, B).
  - 4 gives (0, A).
  - 5 gives (D, A).
  - 6 gives (D, Q).
  - 7 gives (D, 0).
  
  Here A and B are the registers addressed by `a_addr` and `b_addr`, and D is `d_in`.
- R3: The arithmetic codes on `fn_sel` are:
  - 0: F = R + S + `c_in`.
  - 1: F = S + ~R + `c_in`, which with `c_in`=1 is S minus R.
  - 2: F = R + ~S + `c_in`.
  
  In each case the result is taken modulo 16.
- R4: The logic codes on `fn_sel` are:
  - 3: R OR S.
  - 4: R AND S.
  - 5: (NOT R) AND S.
  - 6: R XOR S.
  - 7: NOT (R XOR S).
  
  For all of these, `c_out` and `ovf_out` are 0. D AND zero yields 0000, which clears a register.
- R5: For the arithmetic codes, `c_out` is bit 4 of the 5-bit sum of the two addends and `c_in`. With code 1 and `c_in`=1, this means `c_out` is 1 exactly when S is greater than or equal to R.
- R6: For the arithmetic codes, `ovf_out` is 1 exactly when the true signed result of the operation falls outside the range -8 to +7.
- R7: `zero_out` is 1 exactly when F is 0000, and `sign_out` equals bit 3 of F.
- R8: The destination code on `dst_sel` works as follows:
  - 0: writes F to Q.
  - 1: writes nothing.
  - 2: writes F to register B and drives Y with register A.
  - 3: writes F to register B.
  
  For every code other than 2, Y shows F.
- R9: Destination codes 4 and 5 shift down. Register B receives {`rf_sin_hi`, F[3:1]}, `rf_sout_lo` shows F[0] and `q_sout_lo` shows Q[0]. Code 4 also loads Q with {`q_sin_hi`, Q[3:1]}. Code 5 leaves Q unchanged.
- R10: Destination codes 6 and 7 shift up. Register B receives {F[2:0], `rf_sin_lo`}, `rf_sout_hi` shows F[3] and `q_sout_hi` shows Q[3]. Code 6 also loads Q with {Q[2:0], `q_sin_lo`}. Code 7 leaves Q unchanged.
- R11: Any shift-out output that the current destination code does not drive reads 0. For codes 0 to 3 this applies to all four of them.
- R12: A register that is read and written in the same cycle supplies its old value to the operands. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 4 | Read address of the A operand register |
| b_addr | input | 4 | Read address of the B operand register, and write address |
| src_sel | input | 3 | Operand source code |
| fn_sel | input | 3 | ALU function code |
| dst_sel | input | 3 | Destination and shift code |
| d_in | input | 4 | External data operand |
| c_in | input | 1 | Carry into the arithmetic unit |
| rf_sin_lo | input | 1 | Bit shifted into register bit 0 on an up shift |
| rf_sin_hi | input | 1 | Bit shifted into register bit 3 on a down shift |
| q_sin_lo | input | 1 | Bit shifted into Q bit 0 on an up shift |
| q_sin_hi | input | 1 | Bit shifted into Q bit 3 on a down shift |
| y_out | output | 4 | Data output |
| c_out | output | 1 | Carry out of the arithmetic unit |
| ovf_out | output | 1 | Signed overflow |
| sign_out | output | 1 | Bit 3 of F |
| zero_out | output | 1 | F equals zero |
| rf_sout_lo | output | 1 | F bit 0 leaving on a down shift |
| rf_sout_hi | output | 1 | F bit 3 leaving on an up shift |
| q_sout_lo | output | 1 | Q bit 0 leaving on a down shift |
| q_sout_hi | output | 1 | Q bit 3 leaving on an up shift |

## Verification
A corrupted general register stays hidden until a later operation addresses it. It then shows on Y and on the flags in that same cycle, so every write is followed at some point by a read-back through a source code that passes the register straight through. A wrong Q value reaches the ports one cycle after it is written, either through the Q-sourcing codes or immediately on the Q shift-out pins during a shift. Flag and carry errors are combinational and appear in the same cycle as the operation that causes them, so each operand pair is compared within the cycle it is applied.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    SEL_AQ = 3'd0,
    SEL_AB = 3'd1,
    SEL_ZQ = 3'd2,
    SEL_ZB = 3'd3,
    SEL_ZA = 3'd4,
    SEL_DA = 3'd5,
    SEL_DQ = 3'd6,
    SEL_DZ = 3'd7
  } src_sel_e;

  typedef enum logic [2:0] {
    FN_ADD    = 3'd0,
    FN_SUB_SR = 3'd1,
    FN_SUB_RS = 3'd2,
    FN_OR     = 3'd3,
    FN_AND    = 3'd4,
    FN_ANDN   = 3'd5,
    FN_XOR    = 3'd6,
    FN_XNOR   = 3'd7
  } fn_sel_e;

  typedef enum logic [2:0] {
    DST_Q      = 3'd0,
    DST_NONE   = 3'd1,
    DST_RF_A   = 3'd2,
    DST_RF     = 3'd3,
    DST_RF_QDN = 3'd4,
    DST_RF_DN  = 3'd5,
    DST_RF_QUP = 3'd6,
    DST_RF_UP  = 3'd7
  } dst_sel_e;

endpackage

// File: rtl/slice_regfile.sv
module slice_regfile #(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][W-1:0] mem;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    logic [W-1:0] ent_q;

    assign ent_en = wr_en && (rd_b_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (ent_en) begin
        ent_q <= wr_data;
      end
    end

    assign mem[i] = ent_q;
  end

  assign rd_a = mem[rd_a_addr];
  assign rd_b = mem[rd_b_addr];

endmodule

// File: rtl/slice_operand_mux.sv
module slice_operand_mux
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  src_sel_e       src,
  input  logic [W-1:0]   reg_a,
  input  logic [W-1:0]   reg_b,
  input  logic [W-1:0]   reg_q,
  input  logic [W-1:0]   ext_d,
  output logic [W-1:0]   op_r,
  output logic [W-1:0]   op_s
);
  always_comb begin
    op_r = '0;
    op_s = '0;
    unique case (src)
      SEL_AQ: begin op_r = reg_a; op_s = reg_q; end
      SEL_AB: begin op_r = reg_a; op_s = reg_b; end
      SEL_ZQ: begin op_r = '0;    op_s = reg_q; end
      SEL_ZB: begin op_r = '0;    op_s = reg_b; end
      SEL_ZA: begin op_r = '0;    op_s = reg_a; end
      SEL_DA: begin op_r = ext_d; op_s = reg_a; end
      SEL_DQ: begin op_r = ext_d; op_s = reg_q; end
      SEL_DZ: begin op_r = ext_d; op_s = '0;    end
      default: begin op_r = '0;   op_s = '0;    end
    endcase
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_slice_pkg::*;
#(
  parameter int W = 4
) (
  input  fn_sel_e      fn,
  input  logic [W-1:0] op_r,
  input  logic [W-1:0] op_s,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] add_x, add_y;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic         arith;

  always_comb begin
    add_x = op_r;
    add_y = op_s;
    arith = 1'b1;
    unique case (fn)
      FN_ADD:    begin add_x = op_r;  add_y = op_s;  end
      FN_SUB_SR: begin add_x = ~op_r; add_y = op_s;  end
      FN_SUB_RS: begin add_x = op_r;  add_y = ~op_s; end
      default:   arith = 1'b0;
    endcase
  end

  // Carry into the MSB comes from a sum of the lower W-1 bits.
  assign full_sum = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, cin};
  assign low_sum  = {1'b0, add_x[W-2:0]} + {1'b0, add_y[W-2:0]} + {{(W-1){1'b0}}, cin};

  always_comb begin
    res = full_sum[W-1:0];
    unique case (fn)
      FN_OR:   res = op_r | op_s;
      FN_AND:  res = op_r & op_s;
      FN_ANDN: res = ~op_r & op_s;
      FN_XOR:  res = op_r ^ op_s;
      FN_XNOR: res = ~(op_r ^ op_s);
      default: res = full_sum[W-1:0];
    endcase
  end

  assign cout = arith & full_sum[W];
  assign ovf  = arith & (full_sum[W] ^ low_sum[W-1]);

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr,
  input  logic [AW-1:0] b_addr,
  input  logic [2:0]    src_sel,
  input  logic [2:0]    fn_sel,
  input  logic [2:0]    dst_sel,
  input  logic [W-1:0]  d_in,
  input  logic          c_in,
  input  logic          rf_sin_lo,
  input  logic          rf_sin_hi,
  input  logic          q_sin_lo,
  input  logic          q_sin_hi,
  output logic [W-1:0]  y_out,
  output logic          c_out,
  output logic          ovf_out,
  output logic          sign_out,
  output logic          zero_out,
  output logic          rf_sout_lo,
  output logic          rf_sout_hi,
  output logic          q_sout_lo,
  output logic          q_sout_hi
);
  localparam int MSB = W - 1;

  dst_sel_e     dst;
  logic [1:0]   rst_pipe;
  logic         rst_sync_n;
  logic [W-1:0] reg_a, reg_b, q_q, q_d, op_r, op_s, f_res, rf_wdata;
  logic         rf_we, q_we, alu_cout, alu_ovf;

  assign dst = dst_sel_e'(dst_sel);

  // Reset asserts at once and releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  slice_regfile #(.W(W), .AW(AW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_a_addr (a_addr),
    .rd_b_addr (b_addr),
    .wr_en     (rf_we),
    .wr_data   (rf_wdata),
    .rd_a      (reg_a),
    .rd_b      (reg_b)
  );

  slice_operand_mux #(.W(W)) u_mux (
    .src   (src_sel_e'(src_sel)),
    .reg_a (reg_a),
    .reg_b (reg_b),
    .reg_q (q_q),
    .ext_d (d_in),
    .op_r  (op_r),
    .op_s  (op_s)
  );

  slice_alu #(.W(W)) u_alu (
    .fn   (fn_sel_e'(fn_sel)),
    .op_r (op_r),
    .op_s (op_s),
    .cin  (c_in),
    .res  (f_res),
    .cout (alu_cout),
    .ovf  (alu_ovf)
  );

  // Destination decode: write enables, write data and shift ends.
  always_comb begin
    rf_we      = 1'b0;
    rf_wdata   = f_res;
    q_we       = 1'b0;
    q_d        = f_res;
    y_out      = f_res;
    rf_sout_lo = 1'b0;
    rf_sout_hi = 1'b0;
    q_sout_lo  = 1'b0;
    q_sout_hi  = 1'b0;
    unique case (dst)
      DST_Q:    q_we = 1'b1;
      DST_NONE: ;
      DST_RF_A: begin rf_we = 1'b1; y_out = reg_a; end
      DST_RF:   rf_we = 1'b1;
      DST_RF_QDN, DST_RF_DN: begin
        rf_we      = 1'b1;
        rf_wdata   = {rf_sin_hi, f_res[MSB:1]};
        q_we       = (dst == DST_RF_QDN);
        q_d        = {q_sin_hi, q_q[MSB:1]};
        rf_sout_lo = f_res[0];
        q_sout_lo  = q_q[0];
      end
      DST_RF_QUP, DST_RF_UP: begin
        rf_we      = 1'b1;
        rf_wdata   = {f_res[MSB-1:0], rf_sin_lo};
        q_we       = (dst == DST_RF_QUP);
        q_d        = {q_q[MSB-1:0], q_sin_lo};
        rf_sout_hi = f_res[MSB];
        q_sout_hi  = q_q[MSB];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_q <= '0;
    end else if (q_we) begin
      q_q <= q_d;
    end
  end

  assign c_out    = alu_cout;
  assign ovf_out  = alu_ovf;
  assign sign_out = f_res[MSB];
  assign zero_out = (f_res == '0);

endmodule

// File: rtl/alu_slice_checks.sv
module alu_slice_checks #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   fn_sel,
  input logic [2:0]   dst_sel,
  input logic [W-1:0] y_out,
  input logic [W-1:0] q_q,
  input logic         q_sin_hi,
  input logic         q_sin_lo,
  input logic         c_out,
  input logic         ovf_out,
  input logic         sign_out,
  input logic         zero_out,
  input logic         rf_sout_lo,
  input logic         rf_sout_hi,
  input logic         q_sout_lo,
  input logic         q_sout_hi
);
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel != 3'd2) |-> (zero_out == (y_out == '0)));

  assert_sign_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel != 3'd2) |-> (sign_out == y_out[W-1]));

  assert_logic_no_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel >= 3'd3) |-> (!c_out && !ovf_out));

  assert_quiet_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel <= 3'd3) |-> ({rf_sout_lo, rf_sout_hi, q_sout_lo, q_sout_hi} == 4'b0));

  assert_q_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == 3'd0) |=> (q_q == $past(y_out)));

  assert_q_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd7}) |=> $stable(q_q));

  assert_q_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == 3'd4) |=> (q_q == {$past(q_sin_hi), $past(q_q[W-1:1])}));

  assert_q_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_sel == 3'd6) |=> (q_q == {$past(q_q[W-2:0]), $past(q_sin_lo)}));

endmodule

bind alu_slice alu_slice_checks #(.W(W)) u_checks (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .fn_sel     (fn_sel),
  .dst_sel    (dst_sel),
  .y_out      (y_out),
  .q_q        (q_q),
  .q_sin_hi   (q_sin_hi),
  .q_sin_lo   (q_sin_lo),
  .c_out      (c_out),
  .ovf_out    (ovf_out),
  .sign_out   (sign_out),
  .zero_out   (zero_out),
  .rf_sout_lo (rf_sout_lo),
  .rf_sout_hi (rf_sout_hi),
  .q_sout_lo  (q_sout_lo),
  .q_sout_hi  (q_sout_hi)
);

// File: tb/alu_slice_tb.sv
module alu_slice_tb;

  logic       clk;
  logic       rst_n;
  logic [3:0] a_addr, b_addr, d_in;
  logic [2:0] src_sel, fn_sel, dst_sel;
  logic       c_in, rf_sin_lo, rf_sin_hi, q_sin_lo, q_sin_hi;
  logic [3:0] y_out;
  logic       c_out, ovf_out, sign_out, zero_out;
  logic       rf_sout_lo, rf_sout_hi, q_sout_lo, q_sout_hi;

  alu_slice u_dut (
    .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .b_addr(b_addr),
    .src_sel(src_sel), .fn_sel(fn_sel), .dst_sel(dst_sel), .d_in(d_in),
    .c_in(c_in), .rf_sin_lo(rf_sin_lo), .rf_sin_hi(rf_sin_hi),
    .q_sin_lo(q_sin_lo), .q_sin_hi(q_sin_hi), .y_out(y_out),
    .c_out(c_out), .ovf_out(ovf_out), .sign_out(sign_out),
    .zero_out(zero_out), .rf_sout_lo(rf_sout_lo), .rf_sout_hi(rf_sout_hi),
    .q_sout_lo(q_sout_lo), .q_sout_hi(q_sout_hi)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int    y;
    int    co;
    int    ov;
    int    sg;
    int    zr;
    int    ends;   // {rf_hi, rf_lo, q_hi, q_lo}
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  int   m_rf[16];
  int   m_q;

  function automatic int sgn4(input int v);
    return (v > 7) ? v - 16 : v;
  endfunction

  // sins: [3] rf_sin_hi, [2] rf_sin_lo, [1] q_sin_hi, [0] q_sin_lo
  task automatic step(input int a, input int b, input int src, input int fn,
                      input int dst, input int d, input int cin,
                      input int sins, input string tag);
    int r, s, tot, sv, f, co, ov, ends, wv, ra;
    exp_t e;
    @(negedge clk);
    a_addr = 4'(a); b_addr = 4'(b); src_sel = 3'(src); fn_sel = 3'(fn);
    dst_sel = 3'(dst); d_in = 4'(d); c_in = 1'(cin);
    rf_sin_hi = sins[3]; rf_sin_lo = sins[2];
    q_sin_hi  = sins[1]; q_sin_lo  = sins[0];
    ra = m_rf[a];
    case (src)
      0: begin r = ra;    s = m_q;     end
      1: begin r = ra;    s = m_rf[b]; end
      2: begin r = 0;     s = m_q;     end
      3: begin r = 0;     s = m_rf[b]; end
      4: begin r = 0;     s = ra;      end
      5: begin r = d;     s = ra;      end
      6: begin r = d;     s = m_q;     end
      default: begin r = d; s = 0;     end
    endcase
    tot = 0; sv = 0; co = 0; ov = 0;
    case (fn)
      0: begin tot = r + s + cin;        sv = sgn4(r) + sgn4(s) + cin;     end
      1: begin tot = s + (15 - r) + cin; sv = sgn4(s) - sgn4(r) - 1 + cin; end
      2: begin tot = r + (15 - s) + cin; sv = sgn4(r) - sgn4(s) - 1 + cin; end
      3: tot = r | s;
      4: tot = r & s;
      5: tot = (15 - r) & s;
      6: tot = r ^ s;
      default: tot = 15 - (r ^ s);
    endcase
    f = tot & 15;
    if (fn <= 2) begin
      co = (tot > 15) ? 1 : 0;
      ov = (sv > 7 || sv < -8) ? 1 : 0;
    end
    ends = 0;
    case (dst)
      0: m_q = f;
      2, 3: m_rf[b] = f;
      4, 5: begin
        ends = ((f & 1) << 2) | (m_q & 1);
        wv = (sins[3] << 3) | (f >> 1);
        if (dst == 4) m_q = (sins[1] << 3) | (m_q >> 1);
        m_rf[b] = wv;
      end
      6, 7: begin
        ends = ((f >> 3) << 3) | ((m_q >> 3) << 1);
        wv = ((f << 1) & 15) | sins[2];
        if (dst == 6) m_q = ((m_q << 1) & 15) | sins[0];
        m_rf[b] = wv;
      end
      default: ;
    endcase
    e.y = (dst == 2) ? ra : f;
    e.co = co; e.ov = ov; e.sg = f >> 3; e.zr = (f == 0) ? 1 : 0;
    e.ends = ends; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each queued expectation while its inputs are applied.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        int act_ends;
        e = sb_q.pop_front();
        act_ends = {28'd0, rf_sout_hi, rf_sout_lo, q_sout_hi, q_sout_lo};
        checks++;
        if (int'(y_out) != e.y || int'(c_out) != e.co || int'(ovf_out) != e.ov ||
            int'(sign_out) != e.sg || int'(zero_out) != e.zr || act_ends != e.ends) begin
          errors++;
          $display("FAIL %s: got y=%h co=%0d ov=%0d s=%0d z=%0d ends=%b, expected y=%h co=%0d ov=%0d s=%0d z=%0d ends=%b",
                   e.tag, y_out, c_out, ovf_out, sign_out, zero_out, act_ends[3:0],
                   e.y[3:0], e.co, e.ov, e.sg, e.zr, e.ends[3:0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_rf[i] = 0;
    m_q = 0;
    rst_n = 1'b0;
    a_addr = '0; b_addr = '0; src_sel = '0; fn_sel = '0; dst_sel = 3'd1;
    d_in = '0; c_in = 1'b0;
    rf_sin_lo = 1'b0; rf_sin_hi = 1'b0; q_sin_lo = 1'b0; q_sin_hi = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every register and Q read as zero after reset
    for (int i = 0; i < 16; i++) step(i, 0, 4, 3, 1, 0, 0, 0, "R1 reg");
    step(0, 0, 2, 3, 1, 0, 0, 0, "R1 q");

    // R11: clearing with D AND zero leaves all shift ends at 0
    step(0, 9, 7, 4, 3, 5, 0, 15, "R11 clear");
    step(9, 0, 4, 3, 1, 0, 0, 0, "R11 readback");

    // R8: load registers through D, read back with destination code 2
    for (int i = 0; i < 16; i++) step(0, i, 7, 3, 3, (i * 7 + 3) & 15, 0, 0, "R8 load");
    for (int i = 0; i < 16; i++) step(i, (i + 1) & 15, 4, 3, 1, 0, 0, 0, "R8 read");
    step(3, 12, 7, 3, 2, 10, 0, 0, "R8 show A");
    step(12, 0, 4, 3, 1, 0, 0, 0, "R8 written B");
    step(0, 0, 7, 3, 0, 9, 0, 0, "R8 q load");
    step(0, 4, 7, 3, 1, 6, 0, 0, "R8 nop");
    step(4, 0, 4, 3, 1, 0, 0, 0, "R8 nop readback");
    step(0, 0, 2, 3, 1, 0, 0, 0, "R8 q readback");

    // R2: every source code with two functions
    for (int sc = 0; sc < 8; sc++) begin
      step(2, 5, sc, 0, 1, 6, 0, 0, "R2 add");
      step(2, 5, sc, 6, 1, 6, 0, 0, "R2 xor");
    end

    // R3 R5 R6 R7: exhaustive arithmetic over D and register 0
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        step(0, 0, 7, 3, 3, x, 0, 0, "R3 setup");
        step(0, 0, 5, 0, 1, y, (x + y) & 1, 0, "R3/R5/R6/R7 add");
        step(0, 0, 5, 1, 1, y, 1, 0, "R3/R5/R6 s minus r");
        step(0, 0, 5, 2, 1, y, (x ^ y) & 1, 0, "R3/R5/R6 r minus s");
      end
    end

    // R4: logic functions
    for (int fn = 3; fn < 8; fn++) begin
      for (int x = 0; x < 16; x++) begin
        step(0, 1, 7, 3, 3, x, 0, 0, "R4 setup");
        step(1, 0, 5, fn, 1, (x * 5 + fn) & 15, 1, 0, "R4 logic");
      end
    end

    // R9 R10: shifts with each combination of shift-in bits
    for (int dc = 4; dc < 8; dc++) begin
      for (int si = 0; si < 16; si++) begin
        step(0, 0, 7, 3, 0, (si * 3 + 5) & 15, 0, 0, "R9/R10 q setup");
        step(0, 3, 7, 3, dc, (si * 11 + 6) & 15, 0, si, (dc < 6) ? "R9 down" : "R10 up");
        step(3, 0, 4, 3, 1, 0, 0, 0, (dc < 6) ? "R9 reg" : "R10 reg");
        step(0, 0, 2, 3, 1, 0, 0, 0, (dc < 6) ? "R9 q" : "R10 q");
      end
    end

    // R12: read and write of the same register in one cycle
    step(0, 6, 7, 3, 3, 5, 0, 0, "R12 setup");
    step(6, 6, 1, 0, 3, 0, 0, 0, "R12 old value");
    step(6, 6, 1, 0, 3, 0, 1, 0, "R12 new value");
    step(6, 0, 4, 3, 1, 0, 0, 0, "R12 readback");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule